// File: doc/BRIEF.md
# Floating-Point Control and Status Register

This block holds the 32-bit control and status word that sits beside a floating-point datapath. It stores eight comparison condition codes, a 6-bit cause field describing the exceptions raised by the most recent operation, a 5-bit trap-enable field and a 5-bit field of sticky exception flags. Software can load the whole word, rewrite one field, or set or clear a single condition code. The arithmetic unit posts exception flags, which accumulate into the sticky field.

The condition codes are not contiguous. Code 0 lives at bit 23 and codes 1 to 7 live at bits 25 to 31. The block therefore also presents them as one packed byte, with code 0 in the least significant bit. It also decodes a trap request from the cause and enable fields. Every update takes effect on the clock edge that samples the request. Reset clears the whole word, and reset is released through a two-stage synchronizer.

Top module: `fpcsr_top`

## Requirements
- R1: While reset is applied, and until the first accepted update after release, every bit of the register reads 0, the packed byte and all field outputs read 0, and `trap_o` is low.
- R2: When `wr_word_en` is high, the register holds `wr_word_data` after the next clock edge. A word write overrides every other request made in the same cycle.
- R3: A condition-code operation with index k maps to bit 23 for k = 0 and to bit 24+k for k = 1..7. The bit is set when `cc_op_set` = 1 and cleared when `cc_op_set` = 0. No other bit changes.
- R4: `cc_packed_o` bit 0 equals register bit 23, and `cc_packed_o` bits 7:1 equal register bits 31:25.
- R5: A field write with `fld_sel` = 0 loads `fld_data[5:0]` into bits 17:12 (cause). With `fld_sel` = 1 it loads `fld_data[4:0]` into bits 11:7 (enable). With `fld_sel` = 2 it loads `fld_data[4:0]` into bits 6:2 (flags). With `fld_sel` = 3 it loads packed condition codes from `fld_data[7:0]`, with bit 0 going to register bit 23 and bits 7:1 going to register bits 31:25. Input bits beyond the field are ignored, and all other register bits are kept.
- R6: An accumulate request ORs `acc_flags[4:0]` into bits 6:2. Flags already set stay set until a word write or a flag-field write rewrites them.
- R7: `cause_o`, `enable_o` and `flags_o` present bits 17:12, 11:7 and 6:2 of the register.
- R8: Exception bit positions, used in cause, enable and flags alike, are: inexact = bit 0 (1), underflow = bit 1 (2), overflow = bit 2 (4), divide-by-zero = bit 3 (8), invalid = bit 4 (16), and unimplemented = cause bit 5 (32). `trap_o` is high when any cause bit 0..4 is set together with its enable bit, or when cause bit 5 is set, whatever the enables hold.
- R9: Requests made in the same cycle without a word write are applied in a fixed order: first the field write, then the condition-code operation, then the flag accumulate.
- R10: Bits 24, 22:18 and 1:0 change only on a word write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_word_en | input | 1 | Load the whole register |
| wr_word_data | input | 32 | Word to load |
| fld_wr_en | input | 1 | Field write request |
| fld_sel | input | 2 | Field select: 0 cause, 1 enable, 2 flags, 3 packed condition codes |
| fld_data | input | 8 | Field write value, low bits used |
| cc_op_en | input | 1 | Single condition-code operation request |
| cc_op_set | input | 1 | 1 sets the selected code, 0 clears it |
| cc_op_idx | input | 3 | Condition-code index |
| acc_en | input | 1 | Flag accumulate request from the arithmetic unit |
| acc_flags | input | 5 | Exception flags to accumulate |
| csr_o | output | 32 | Full register contents |
| cc_packed_o | output | 8 | Condition codes packed, code 0 in bit 0 |
| cause_o | output | 6 | Cause field |
| enable_o | output | 5 | Enable field |
| flags_o | output | 5 | Sticky flag field |
| trap_o | output | 1 | Trap request |

## Verification
The hardest situation to reach from the ports is a single cycle that carries a packed condition-code field write, a condition-code clear that targets one of the bits just written, and a flag accumulate, all at once. Only the fixed order exposes the result in that cycle. The stimulus issues this combination directly, and the random phase then drives all four request kinds at independent rates, with word writes kept rare so that long runs of composed updates build up. A trap caused only by the unimplemented bit, with every enable clear, is set up through a cause-field write followed by an enable-field write of zero.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;

  localparam int CSR_W      = 32;
  localparam int CC_NUM     = 8;
  localparam int CC_IDX_W   = $clog2(CC_NUM);
  localparam int CC0_POS    = 23;
  localparam int CC_HI_BASE = 24;
  localparam int CAUSE_LSB  = 12;
  localparam int CAUSE_W    = 6;
  localparam int EN_LSB     = 7;
  localparam int EN_W       = 5;
  localparam int FLG_LSB    = 2;
  localparam int FLG_W      = 5;
  localparam int FLD_IN_W   = 8;
  localparam int RST_STAGES = 2;

  typedef enum logic [1:0] {
    FSEL_CAUSE  = 2'd0,
    FSEL_ENABLE = 2'd1,
    FSEL_FLAGS  = 2'd2,
    FSEL_COND   = 2'd3
  } fsel_e;

  // Bit position of condition code idx inside the register
  function automatic int cc_bit_pos(int idx);
    return (idx == 0) ? CC0_POS : CC_HI_BASE + idx;
  endfunction

  function automatic logic [CSR_W-1:0] cc_all_mask();
    logic [CSR_W-1:0] m;
    m = '0;
    for (int i = 0; i < CC_NUM; i++) m[cc_bit_pos(i)] = 1'b1;
    return m;
  endfunction

  localparam logic [CSR_W-1:0] CAUSE_MASK = CSR_W'({CAUSE_W{1'b1}}) << CAUSE_LSB;
  localparam logic [CSR_W-1:0] EN_MASK    = CSR_W'({EN_W{1'b1}}) << EN_LSB;
  localparam logic [CSR_W-1:0] FLG_MASK   = CSR_W'({FLG_W{1'b1}}) << FLG_LSB;
  localparam logic [CSR_W-1:0] CC_MASK    = cc_all_mask();
  localparam logic [CSR_W-1:0] SPARE_MASK = ~(CAUSE_MASK | EN_MASK | FLG_MASK | CC_MASK);

endpackage

// File: rtl/fpcsr_cc_map.sv
module fpcsr_cc_map
  import fpcsr_pkg::*;
(
  input  logic [CSR_W-1:0]    csr_i,
  input  logic [CC_IDX_W-1:0] idx_i,
  input  logic [CC_NUM-1:0]   pk_i,
  output logic [CC_NUM-1:0]   pk_o,
  output logic [CSR_W-1:0]    idx_mask_o,
  output logic [CSR_W-1:0]    spread_o
);

  // Gather the scattered codes into one byte
  for (genvar g = 0; g < CC_NUM; g++) begin : g_pack
    localparam int POS = cc_bit_pos(g);
    assign pk_o[g] = csr_i[POS];
  end

  // Decode a single index and scatter a packed byte back to positions
  always_comb begin
    idx_mask_o = '0;
    spread_o   = '0;
    for (int i = 0; i < CC_NUM; i++) begin
      spread_o[cc_bit_pos(i)] = pk_i[i];
      if (idx_i == CC_IDX_W'(i)) idx_mask_o[cc_bit_pos(i)] = 1'b1;
    end
  end

endmodule

// File: rtl/fpcsr_next.sv
module fpcsr_next
  import fpcsr_pkg::*;
(
  input  logic [CSR_W-1:0]    q_i,
  input  logic                word_en_i,
  input  logic [CSR_W-1:0]    word_data_i,
  input  logic                fld_en_i,
  input  fsel_e               fld_sel_i,
  input  logic [FLD_IN_W-1:0] fld_data_i,
  input  logic [CSR_W-1:0]    cc_spread_i,
  input  logic                cc_en_i,
  input  logic                cc_set_i,
  input  logic [CSR_W-1:0]    cc_idx_mask_i,
  input  logic                acc_en_i,
  input  logic [FLG_W-1:0]    acc_flags_i,
  output logic [CSR_W-1:0]    d_o,
  output logic                ld_en_o
);

  logic [CSR_W-1:0] after_fld;
  logic [CSR_W-1:0] after_cc;
  logic [CSR_W-1:0] after_acc;
  logic [CSR_W-1:0] fld_val;
  logic [CSR_W-1:0] fld_mask;
  logic [CSR_W-1:0] acc_val;

  // Stage 1: field write, upper input bits dropped by slicing
  always_comb begin
    fld_val  = '0;
    fld_mask = '0;
    unique case (fld_sel_i)
      FSEL_CAUSE: begin
        fld_val[CAUSE_LSB +: CAUSE_W] = fld_data_i[CAUSE_W-1:0];
        fld_mask = CAUSE_MASK;
      end
      FSEL_ENABLE: begin
        fld_val[EN_LSB +: EN_W] = fld_data_i[EN_W-1:0];
        fld_mask = EN_MASK;
      end
      FSEL_FLAGS: begin
        fld_val[FLG_LSB +: FLG_W] = fld_data_i[FLG_W-1:0];
        fld_mask = FLG_MASK;
      end
      default: begin
        fld_val  = cc_spread_i;
        fld_mask = CC_MASK;
      end
    endcase
    after_fld = fld_en_i ? ((q_i & ~fld_mask) | fld_val) : q_i;
  end

  // Stage 2: single condition-code set or clear
  always_comb begin
    if (!cc_en_i)      after_cc = after_fld;
    else if (cc_set_i) after_cc = after_fld | cc_idx_mask_i;
    else               after_cc = after_fld & ~cc_idx_mask_i;
  end

  // Stage 3: sticky flag accumulate
  always_comb begin
    acc_val = '0;
    acc_val[FLG_LSB +: FLG_W] = acc_flags_i;
    after_acc = acc_en_i ? (after_cc | acc_val) : after_cc;
  end

  assign d_o     = word_en_i ? word_data_i : after_acc;
  assign ld_en_o = word_en_i | fld_en_i | cc_en_i | acc_en_i;

endmodule

// File: rtl/fpcsr_trap_eval.sv
module fpcsr_trap_eval
  import fpcsr_pkg::*;
(
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [EN_W-1:0]    enable_i,
  output logic               trap_o
);

  localparam int FORCED_W = CAUSE_W - EN_W;

  logic masked_hit;
  logic forced_hit;

  assign masked_hit = |(cause_i[EN_W-1:0] & enable_i);
  // Cause bits without an enable partner always raise a trap
  assign forced_hit = |cause_i[CAUSE_W-1 -: FORCED_W];
  assign trap_o     = masked_hit | forced_hit;

endmodule

// File: rtl/fpcsr_top.sv
module fpcsr_top
  import fpcsr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_word_en,
  input  logic [31:0] wr_word_data,
  input  logic        fld_wr_en,
  input  logic [1:0]  fld_sel,
  input  logic [7:0]  fld_data,
  input  logic        cc_op_en,
  input  logic        cc_op_set,
  input  logic [2:0]  cc_op_idx,
  input  logic        acc_en,
  input  logic [4:0]  acc_flags,
  output logic [31:0] csr_o,
  output logic [7:0]  cc_packed_o,
  output logic [5:0]  cause_o,
  output logic [4:0]  enable_o,
  output logic [4:0]  flags_o,
  output logic        trap_o
);

  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_s_n;
  logic [CSR_W-1:0]      csr_q;
  logic [CSR_W-1:0]      csr_d;
  logic                  csr_ld;
  logic [CSR_W-1:0]      cc_idx_mask;
  logic [CSR_W-1:0]      cc_spread;

  // Reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[RST_STAGES-1];

  fpcsr_cc_map u_cc_map (
    .csr_i      (csr_q),
    .idx_i      (cc_op_idx),
    .pk_i       (fld_data[CC_NUM-1:0]),
    .pk_o       (cc_packed_o),
    .idx_mask_o (cc_idx_mask),
    .spread_o   (cc_spread)
  );

  fpcsr_next u_next (
    .q_i           (csr_q),
    .word_en_i     (wr_word_en),
    .word_data_i   (wr_word_data),
    .fld_en_i      (fld_wr_en),
    .fld_sel_i     (fsel_e'(fld_sel)),
    .fld_data_i    (fld_data),
    .cc_spread_i   (cc_spread),
    .cc_en_i       (cc_op_en),
    .cc_set_i      (cc_op_set),
    .cc_idx_mask_i (cc_idx_mask),
    .acc_en_i      (acc_en),
    .acc_flags_i   (acc_flags),
    .d_o           (csr_d),
    .ld_en_o       (csr_ld)
  );

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)    csr_q <= '0;
    else if (csr_ld) csr_q <= csr_d;
  end

  assign csr_o    = csr_q;
  assign cause_o  = csr_q[CAUSE_LSB +: CAUSE_W];
  assign enable_o = csr_q[EN_LSB +: EN_W];
  assign flags_o  = csr_q[FLG_LSB +: FLG_W];

  fpcsr_trap_eval u_trap (
    .cause_i  (cause_o),
    .enable_i (enable_o),
    .trap_o   (trap_o)
  );

  // R2: a word write wins over everything else
  a_r2_word_load: assert property (@(posedge clk) disable iff (!rst_s_n)
    wr_word_en |=> csr_o == $past(wr_word_data));

  // R3: set lands on the indexed code; accumulate cannot touch codes
  a_r3_cc_set: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cc_op_en && cc_op_set && !wr_word_en) |=> cc_packed_o[$past(cc_op_idx)]);

  a_r3_cc_clear: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cc_op_en && !cc_op_set && !wr_word_en) |=> !cc_packed_o[$past(cc_op_idx)]);

  // R5: a cause write leaves every bit outside the cause field alone
  a_r5_cause_only: assert property (@(posedge clk) disable iff (!rst_s_n)
    (fld_wr_en && fld_sel == FSEL_CAUSE && !wr_word_en && !cc_op_en && !acc_en)
    |=> (csr_o & ~CAUSE_MASK) == ($past(csr_o) & ~CAUSE_MASK));

  // R6: flags never drop without a word or flag-field write
  a_r6_flags_sticky: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!wr_word_en && !(fld_wr_en && fld_sel == FSEL_FLAGS))
    |=> (flags_o & $past(flags_o)) == $past(flags_o));

  // R8: unimplemented cause forces a trap regardless of enables
  a_r8_unimpl_trap: assert property (@(posedge clk) disable iff (!rst_s_n)
    csr_q[CAUSE_LSB + CAUSE_W - 1] |-> trap_o);

  // R10: spare bits move only on a word write
  a_r10_spare_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    !wr_word_en |=> (csr_o & SPARE_MASK) == ($past(csr_o) & SPARE_MASK));

endmodule

// File: tb/fpcsr_top_bench.sv
module fpcsr_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_word_en = 1'b0;
  logic [31:0] wr_word_data = '0;
  logic        fld_wr_en = 1'b0;
  logic [1:0]  fld_sel = '0;
  logic [7:0]  fld_data = '0;
  logic        cc_op_en = 1'b0;
  logic        cc_op_set = 1'b0;
  logic [2:0]  cc_op_idx = '0;
  logic        acc_en = 1'b0;
  logic [4:0]  acc_flags = '0;
  logic [31:0] csr_o;
  logic [7:0]  cc_packed_o;
  logic [5:0]  cause_o;
  logic [4:0]  enable_o;
  logic [4:0]  flags_o;
  logic        trap_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] mdl = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fpcsr_top u_fpcsr_top (
    .clk(clk), .rst_n(rst_n),
    .wr_word_en(wr_word_en), .wr_word_data(wr_word_data),
    .fld_wr_en(fld_wr_en), .fld_sel(fld_sel), .fld_data(fld_data),
    .cc_op_en(cc_op_en), .cc_op_set(cc_op_set), .cc_op_idx(cc_op_idx),
    .acc_en(acc_en), .acc_flags(acc_flags),
    .csr_o(csr_o), .cc_packed_o(cc_packed_o), .cause_o(cause_o),
    .enable_o(enable_o), .flags_o(flags_o), .trap_o(trap_o)
  );

  function automatic int ccpos(int k);
    if (k == 0) return 23;
    return 24 + k;
  endfunction

  // Behavioural next value, in requirement order
  function automatic logic [31:0] model_step(logic [31:0] q);
    logic [31:0] r;
    r = q;
    if (wr_word_en) return wr_word_data;
    if (fld_wr_en) begin
      case (fld_sel)
        2'd0: for (int b = 0; b < 6; b++) r[12 + b] = fld_data[b];
        2'd1: for (int b = 0; b < 5; b++) r[7 + b]  = fld_data[b];
        2'd2: for (int b = 0; b < 5; b++) r[2 + b]  = fld_data[b];
        default: for (int k = 0; k < 8; k++) r[ccpos(k)] = fld_data[k];
      endcase
    end
    if (cc_op_en) r[ccpos(int'(cc_op_idx))] = cc_op_set;
    if (acc_en) for (int b = 0; b < 5; b++) if (acc_flags[b]) r[2 + b] = 1'b1;
    return r;
  endfunction

  task automatic chk32(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all(string ctx);
    logic [7:0] pk;
    logic       tr;
    for (int k = 0; k < 8; k++) pk[k] = mdl[ccpos(k)];
    tr = mdl[17];
    for (int b = 0; b < 5; b++) if (mdl[12 + b] && mdl[7 + b]) tr = 1'b1;
    chk32({"R1 R2 R3 R5 R6 R9 R10 register ", ctx}, csr_o, mdl);
    chk32({"R4 packed codes ", ctx}, {24'd0, cc_packed_o}, {24'd0, pk});
    chk32({"R7 cause ", ctx}, {26'd0, cause_o}, {26'd0, mdl[17:12]});
    chk32({"R7 enable ", ctx}, {27'd0, enable_o}, {27'd0, mdl[11:7]});
    chk32({"R7 flags ", ctx}, {27'd0, flags_o}, {27'd0, mdl[6:2]});
    chk32({"R8 trap ", ctx}, {31'd0, trap_o}, {31'd0, tr});
  endtask

  task automatic idle_inputs();
    wr_word_en = 1'b0; fld_wr_en = 1'b0; cc_op_en = 1'b0; acc_en = 1'b0;
  endtask

  // Inputs change at the falling edge; results sampled 1 ns after the rise
  task automatic cycle(string ctx);
    @(posedge clk);
    mdl = model_step(mdl);
    #1;
    compare_all(ctx);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic word(logic [31:0] v, string ctx);
    wr_word_en = 1'b1; wr_word_data = v; cycle(ctx);
  endtask

  task automatic fld(logic [1:0] s, logic [7:0] v, string ctx);
    fld_wr_en = 1'b1; fld_sel = s; fld_data = v; cycle(ctx);
  endtask

  task automatic ccop(logic set, logic [2:0] idx, string ctx);
    cc_op_en = 1'b1; cc_op_set = set; cc_op_idx = idx; cycle(ctx);
  endtask

  task automatic acc(logic [4:0] f, string ctx);
    acc_en = 1'b1; acc_flags = f; cycle(ctx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state, held while reset is applied and during release
    repeat (3) @(negedge clk);
    #1 compare_all("in reset");
    rst_n = 1'b1;
    repeat (4) cycle("reset release idle");

    // R2: full word load
    word(32'hFFFF_FFFF, "R2 all ones");
    word(32'h0000_0000, "R2 all zeros");

    // R3 and R4: single code operations, code 0 at bit 23
    ccop(1'b1, 3'd0, "R3 set code0");
    ccop(1'b1, 3'd7, "R3 set code7");
    ccop(1'b1, 3'd1, "R3 set code1");
    ccop(1'b0, 3'd0, "R3 clear code0");
    ccop(1'b1, 3'd4, "R3 set code4");

    // R5: field writes with excess input bits
    fld(2'd0, 8'hFF, "R5 cause masked");
    fld(2'd1, 8'hE5, "R5 enable masked");
    fld(2'd2, 8'hFF, "R5 flags masked");
    fld(2'd3, 8'hA5, "R5 packed cond write");
    fld(2'd2, 8'h00, "R5 flags cleared");

    // R6: sticky accumulate
    acc(5'h01, "R6 inexact");
    acc(5'h10, "R6 invalid adds");
    acc(5'h00, "R6 nothing clears");

    // R8: trap decode
    fld(2'd0, 8'h20, "R8 unimplemented cause");
    fld(2'd1, 8'h00, "R8 unimplemented with no enables");
    fld(2'd0, 8'h04, "R8 overflow cause");
    fld(2'd1, 8'h08, "R8 overflow not enabled");
    fld(2'd1, 8'h04, "R8 overflow enabled");

    // R9: composed same-cycle requests
    fld_wr_en = 1'b1; fld_sel = 2'd3; fld_data = 8'hFF;
    cc_op_en = 1'b1; cc_op_set = 1'b0; cc_op_idx = 3'd2;
    acc_en = 1'b1; acc_flags = 5'h02;
    cycle("R9 cond write then clear then accumulate");
    fld_wr_en = 1'b1; fld_sel = 2'd2; fld_data = 8'h00;
    acc_en = 1'b1; acc_flags = 5'h08;
    cycle("R9 flag write then accumulate");
    // R2: word write wins over all others
    wr_word_en = 1'b1; wr_word_data = 32'h1234_5678;
    fld_wr_en = 1'b1; fld_sel = 2'd0; fld_data = 8'h3F;
    cc_op_en = 1'b1; cc_op_set = 1'b1; cc_op_idx = 3'd5;
    acc_en = 1'b1; acc_flags = 5'h1F;
    cycle("R2 word overrides");

    // R10: spare bits untouched by field, code and flag operations
    word(32'h017C_0003, "R10 spare bits loaded");
    fld(2'd0, 8'h00, "R10 after cause");
    fld(2'd3, 8'h00, "R10 after cond");
    ccop(1'b1, 3'd0, "R10 after code set");
    acc(5'h1F, "R10 after accumulate");

    // Random mix of all requests
    for (int n = 0; n < 400; n++) begin
      logic [31:0] rv;
      rv = $urandom;
      wr_word_en   = (rv[3:0] == 4'd0);
      wr_word_data = $urandom;
      fld_wr_en    = rv[4] & rv[5];
      fld_sel      = rv[7:6];
      fld_data     = rv[15:8];
      cc_op_en     = rv[16];
      cc_op_set    = rv[17];
      cc_op_idx    = rv[20:18];
      acc_en       = rv[21] & rv[22];
      acc_flags    = rv[27:23];
      cycle("random R9");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule